// File: doc/BRIEF.md
# Synchronized SPI Slave Peripheral

This block is a register-mapped SPI peripheral living entirely in the system clock domain. An external master drives the serial clock, select and data-in lines. The block passes all three through synchronizer chains and shifts one character per select assertion. The character length and the clock phase and polarity are programmable. The outgoing character is taken from the data register at the moment select is seen asserted. The received character replaces the data register contents when the last bit arrives.

Software reaches the block through a four-word host bus with combinational read data and single-cycle writes. A status word holds four sticky flags: completion, overrun, collision and abort. Software clears any of them by writing a one to its bit. A master-enable bit exists only to detect bus contention: while it is set, an asserted select input raises the collision flag and no transfer takes place. The serial clock must run at no more than one eighth of the system clock.

Top module: `spis_slave_top`

## Requirements
- R1: After reset every register reads 0 and irq and spi_miso_oe are low. Register map by bus_addr: 0 control (bit0 enable, bit1 master-enable, bit2 phase, bit3 polarity, bit4 interrupt enable, bit5 start), 1 mode (bits[2:0] length code, bit7 select-as-output), 2 data, 3 status (bit0 done, bit1 overrun, bit2 collision, bit3 abort, bit4 busy, read-only).
- R2: The block acts as a slave only when enable=1, master-enable=0 and mode bit7=0. spi_miso_oe is high exactly while it acts as a slave and the synchronized select (active low) is asserted. In that same window status bit4 reads 1.
- R3: A length code of 0 means 8 bits, and codes 1 to 7 mean that many bits. Bits travel MSB first. A completed character is stored right-aligned in the data register, with its upper bits zero, and sets the done flag.
- R4: Polarity sets the idle level of the serial clock. With phase 0 the slave samples on the leading edge and changes MISO on the trailing edge. With phase 1 it changes MISO on the leading edges after the first and samples on the trailing edge. All four combinations work.
- R5: The character sent on MISO is the low bits of the data register as it stood when select asserted. When software has not written the register since the last transfer, that is the previously received character.
- R6: A host write to the data register while busy sets the overrun flag and leaves the data register unchanged.
- R7: When enable and master-enable are both 1 and mode bit7 is 0, an asserted select sets the collision flag, and MISO stays disabled.
- R8: If select deasserts before the last bit of the character is sampled, the abort and done flags both set and the data register keeps its value.
- R9: Writing control with bit5=1 sets the done flag. Bit5 is never stored and reads back as 0.
- R10: irq is high exactly when the interrupt-enable bit is 1 and at least one of the four status flags is set.
- R11: Writing status clears each flag whose bit is 1 in the write data and leaves the other flags unchanged. A flag set in the same cycle stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Host access strobe |
| bus_wr | input | 1 | Host write qualifier |
| bus_addr | input | 2 | Register word select |
| bus_wdata | input | DATA_W | Host write data |
| bus_rdata | output | DATA_W | Register read data (combinational) |
| spi_sck | input | 1 | Serial clock from master |
| spi_ss_n | input | 1 | Slave select, active low |
| spi_mosi | input | 1 | Serial data from master |
| spi_miso | output | 1 | Serial data to master |
| spi_miso_oe | output | 1 | Output enable for the MISO driver |
| irq | output | 1 | Interrupt request |

## Verification
A bit counter that slips shows up on MISO within one serial clock period: every later bit of the character the master collects is shifted. A miscounted length also changes the stored character or raises a spurious abort when select rises. A wrong phase or polarity decode corrupts the first or last bit in both directions, so one transfer per mode exposes it. Flag faults show within one system cycle on the status word and on irq, because the flags are read directly after each stimulus and before the next.

// File: rtl/spis_pkg.sv
package spis_pkg;
   localparam int unsigned ADDR_W = 2;

   typedef enum logic [ADDR_W-1:0] {
      REG_CTRL = 2'd0,
      REG_MODE = 2'd1,
      REG_DATA = 2'd2,
      REG_STAT = 2'd3
   } spis_reg_e;

   // control word bit positions
   localparam int unsigned CTL_EN    = 0;
   localparam int unsigned CTL_MST   = 1;
   localparam int unsigned CTL_CPHA  = 2;
   localparam int unsigned CTL_CPOL  = 3;
   localparam int unsigned CTL_IRQEN = 4;
   localparam int unsigned CTL_START = 5;
   localparam int unsigned CTL_STORED = 5;   // bits below START are kept

   // mode word: length code at the bottom, select direction at bit 7
   localparam int unsigned MODE_SSOUT = 7;

   // status word bit positions
   localparam int unsigned ST_DONE = 0;
   localparam int unsigned ST_OVR  = 1;
   localparam int unsigned ST_COL  = 2;
   localparam int unsigned ST_ABT  = 3;
   localparam int unsigned ST_BUSY = 4;
   localparam int unsigned NFLAGS  = 4;
endpackage

// File: rtl/spis_sync.sv
module spis_sync #(
   parameter int unsigned       W       = 1,
   parameter int unsigned       STAGES  = 2,
   parameter logic [W-1:0]      RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/spis_shifter.sv
module spis_shifter #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned LEN_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              ss_n_s,
   input  logic              sck_s,
   input  logic              mosi_s,
   input  logic              cpol,
   input  logic              cpha,
   input  logic [LEN_W-1:0]  len_code,
   input  logic [DATA_W-1:0] load_data,
   output logic              miso,
   output logic              busy,
   output logic              rx_valid,
   output logic              abort_p,
   output logic [DATA_W-1:0] rx_data
);
   localparam int unsigned     CNT_W = LEN_W + 1;
   localparam logic [CNT_W-1:0] FULL  = CNT_W'(DATA_W);

   logic              sck_q, sel, sel_q, finished, first;
   logic              rise, fall, lead, trail, samp, shft;
   logic [CNT_W-1:0]  nbits, shamt, cnt, cnt_nx;
   logic [DATA_W-1:0] tx_sr, rx_sr, mask;

   assign rise  = sck_s & ~sck_q;
   assign fall  = ~sck_s & sck_q;
   assign lead  = cpol ? fall : rise;
   assign trail = cpol ? rise : fall;
   assign samp  = cpha ? trail : lead;
   assign shft  = cpha ? lead  : trail;

   assign sel    = active & ~ss_n_s;
   assign nbits  = (len_code == '0) ? FULL : {1'b0, len_code};
   assign shamt  = FULL - nbits;
   assign cnt_nx = cnt + CNT_W'(1);

   for (genvar i = 0; i < DATA_W; i++) begin : g_mask
      assign mask[i] = (CNT_W'(i) < nbits);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q    <= 1'b0;
         sel_q    <= 1'b0;
         finished <= 1'b0;
         first    <= 1'b0;
         cnt      <= '0;
         tx_sr    <= '0;
         rx_sr    <= '0;
         rx_valid <= 1'b0;
         abort_p  <= 1'b0;
      end else begin
         sck_q    <= sck_s;
         sel_q    <= sel;
         rx_valid <= 1'b0;
         abort_p  <= 1'b0;
         if (sel && !sel_q) begin
            tx_sr    <= load_data << shamt;
            cnt      <= '0;
            first    <= 1'b1;
            finished <= 1'b0;
         end else if (sel && !finished) begin
            if (samp) begin
               rx_sr <= {rx_sr[DATA_W-2:0], mosi_s};
               cnt   <= cnt_nx;
               if (cnt_nx == nbits) begin
                  finished <= 1'b1;
                  rx_valid <= 1'b1;
               end
            end
            if (shft) begin
               if (cpha && first) first <= 1'b0;
               else               tx_sr <= tx_sr << 1;
            end
         end
         if (!sel && sel_q && !finished) abort_p <= 1'b1;
      end
   end

   assign miso    = tx_sr[DATA_W-1];
   assign busy    = sel;
   assign rx_data = rx_sr & mask;
endmodule

// File: rtl/spis_regs.sv
module spis_regs
   import spis_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned LEN_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              busy,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              abort_p,
   input  logic              col_cond,
   output logic [DATA_W-1:0] ctrl_q,
   output logic [DATA_W-1:0] mode_q,
   output logic [DATA_W-1:0] data_q,
   output logic [NFLAGS-1:0] flags_q,
   output logic [DATA_W-1:0] bus_rdata
);
   localparam logic [DATA_W-1:0] CTRL_WMASK = DATA_W'((1 << CTL_STORED) - 1);
   localparam logic [DATA_W-1:0] MODE_WMASK =
      DATA_W'((1 << MODE_SSOUT) | ((1 << LEN_W) - 1));

   logic              wr_ctl, wr_mode, wr_data, wr_stat;
   logic [NFLAGS-1:0] set_v, clr_v;

   assign wr_ctl  = bus_sel & bus_wr & (bus_addr == REG_CTRL);
   assign wr_mode = bus_sel & bus_wr & (bus_addr == REG_MODE);
   assign wr_data = bus_sel & bus_wr & (bus_addr == REG_DATA);
   assign wr_stat = bus_sel & bus_wr & (bus_addr == REG_STAT);

   always_comb begin
      set_v          = '0;
      set_v[ST_DONE] = rx_valid | abort_p | (wr_ctl & bus_wdata[CTL_START]);
      set_v[ST_OVR]  = wr_data & busy;
      set_v[ST_COL]  = col_cond;
      set_v[ST_ABT]  = abort_p;
      clr_v          = wr_stat ? bus_wdata[NFLAGS-1:0] : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         mode_q  <= '0;
         data_q  <= '0;
         flags_q <= '0;
      end else begin
         if (wr_ctl)  ctrl_q <= bus_wdata & CTRL_WMASK;
         if (wr_mode) mode_q <= bus_wdata & MODE_WMASK;
         if (rx_valid)               data_q <= rx_data;
         else if (wr_data && !busy)  data_q <= bus_wdata;
         flags_q <= (flags_q & ~clr_v) | set_v;
      end
   end

   always_comb begin
      unique case (bus_addr)
         REG_CTRL: bus_rdata = ctrl_q;
         REG_MODE: bus_rdata = mode_q;
         REG_DATA: bus_rdata = data_q;
         default:  bus_rdata = DATA_W'({busy, flags_q});
      endcase
   end
endmodule

// File: rtl/spis_slave_top.sv
module spis_slave_top
   import spis_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [1:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              spi_sck,
   input  logic              spi_ss_n,
   input  logic              spi_mosi,
   output logic              spi_miso,
   output logic              spi_miso_oe,
   output logic              irq
);
   localparam int unsigned LEN_W = $clog2(DATA_W);

   if (DATA_W < 8) begin : g_bad_width
      $error("spis_slave_top: DATA_W must be at least 8");
   end
   if ((1 << LEN_W) != DATA_W) begin : g_bad_pow2
      $error("spis_slave_top: DATA_W must be a power of two");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("spis_slave_top: SYNC_STAGES must be at least 2");
   end

   logic              sck_s, ss_n_s, mosi_s;
   logic              slave_active, col_cond, busy, rx_valid, abort_p;
   logic [DATA_W-1:0] ctrl_q, mode_q, data_q, rx_data;
   logic [NFLAGS-1:0] flags_q;

   spis_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
      .clk (clk),
      .rst_n (rst_n),
      .d   ({spi_sck, spi_ss_n, spi_mosi}),
      .q   ({sck_s, ss_n_s, mosi_s})
   );

   assign slave_active = ctrl_q[CTL_EN] & ~ctrl_q[CTL_MST] & ~mode_q[MODE_SSOUT];
   assign col_cond     = ctrl_q[CTL_EN] & ctrl_q[CTL_MST] & ~mode_q[MODE_SSOUT] & ~ss_n_s;

   spis_shifter #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .active    (slave_active),
      .ss_n_s    (ss_n_s),
      .sck_s     (sck_s),
      .mosi_s    (mosi_s),
      .cpol      (ctrl_q[CTL_CPOL]),
      .cpha      (ctrl_q[CTL_CPHA]),
      .len_code  (mode_q[LEN_W-1:0]),
      .load_data (data_q),
      .miso      (spi_miso),
      .busy      (busy),
      .rx_valid  (rx_valid),
      .abort_p   (abort_p),
      .rx_data   (rx_data)
   );

   spis_regs #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .busy      (busy),
      .rx_valid  (rx_valid),
      .rx_data   (rx_data),
      .abort_p   (abort_p),
      .col_cond  (col_cond),
      .ctrl_q    (ctrl_q),
      .mode_q    (mode_q),
      .data_q    (data_q),
      .flags_q   (flags_q),
      .bus_rdata (bus_rdata)
   );

   assign spi_miso_oe = busy;
   assign irq         = ctrl_q[CTL_IRQEN] & (|flags_q);
endmodule

// File: rtl/spis_checker.sv
module spis_checker
   import spis_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [1:0]        bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              busy,
   input logic [DATA_W-1:0] data_q,
   input logic [NFLAGS-1:0] flags_q,
   input logic              rx_valid,
   input logic [DATA_W-1:0] rx_data,
   input logic              abort_p,
   input logic              col_cond,
   input logic              ss_n_s,
   input logic              miso_oe
);
   p_oe_needs_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ss_n_s |-> !miso_oe);

   p_char_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> (flags_q[ST_DONE] && data_q == $past(rx_data)));

   p_busy_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && bus_addr == REG_DATA && busy && !rx_valid)
      |=> (flags_q[ST_OVR] && $stable(data_q)));

   p_collision_r7: assert property (@(posedge clk) disable iff (!rst_n)
      col_cond |=> flags_q[ST_COL]);

   p_abort_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
      abort_p |=> (flags_q[ST_ABT] && flags_q[ST_DONE]));

   p_clear_col_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && bus_addr == REG_STAT && bus_wdata[ST_COL] && !col_cond)
      |=> !flags_q[ST_COL]);
endmodule

bind spis_slave_top spis_checker #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .busy      (busy),
   .data_q    (data_q),
   .flags_q   (flags_q),
   .rx_valid  (rx_valid),
   .rx_data   (rx_data),
   .abort_p   (abort_p),
   .col_cond  (col_cond),
   .ss_n_s    (ss_n_s),
   .miso_oe   (spi_miso_oe)
);

// File: tb/tb_spis_slave_top.sv
module tb_spis_slave_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_sel = 1'b0, bus_wr = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [7:0] bus_wdata = 8'd0, bus_rdata;
   logic       spi_sck = 1'b0, spi_ss_n = 1'b1, spi_mosi = 1'b0;
   logic       spi_miso, spi_miso_oe, irq;

   int checks = 0;
   int fails  = 0;
   logic [7:0] exp_q[$];
   logic [7:0] obs_q[$];
   logic       oe_seen;
   logic [7:0] v;

   always #2 clk = ~clk;   // 250 MHz

   spis_slave_top dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .spi_sck(spi_sck), .spi_ss_n(spi_ss_n), .spi_mosi(spi_mosi),
      .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe), .irq(irq));

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic half();
      repeat (8) @(negedge clk);
   endtask

   // driver: plays the master and queues the expected MISO character
   task automatic xfer(input logic cpol, input logic cpha, input int nb,
                       input logic [7:0] mosi_val, input logic [7:0] exp_miso,
                       input int nclk, input bit score);
      logic [7:0] obs = 8'd0;
      logic [7:0] m = 8'((16'd1 << nclk) - 16'd1);
      spi_ss_n = 1'b0;
      half();
      oe_seen = spi_miso_oe;
      for (int i = 0; i < nclk; i++) begin
         if (!cpha) begin
            spi_mosi = mosi_val[nb-1-i];
            half();
            obs = {obs[6:0], spi_miso};
            spi_sck = ~cpol;
            half();
            spi_sck = cpol;
         end else begin
            spi_sck = ~cpol;
            spi_mosi = mosi_val[nb-1-i];
            half();
            obs = {obs[6:0], spi_miso};
            spi_sck = cpol;
            half();
         end
      end
      half();
      spi_ss_n = 1'b1;
      half(); half();
      if (score) begin
         exp_q.push_back(exp_miso & m);
         obs_q.push_back(obs & m);
      end
   endtask

   // monitor: compares what the master collected against the queue
   initial begin
      forever begin
         @(negedge clk);
         if (obs_q.size() > 0 && exp_q.size() > 0)
            chk("R5/R4 miso character", int'(obs_q.pop_front()), int'(exp_q.pop_front()));
      end
   end

   task automatic finish_run();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      for (int a = 0; a < 4; a++) begin
         rd(2'(a), v);
         chk("R1 reset register", v, 0);
      end
      chk("R1 reset irq", irq, 0);
      chk("R1 reset oe", spi_miso_oe, 0);

      // mode 0, 8 bits
      wr(2'd0, 8'h01); wr(2'd1, 8'h00); wr(2'd2, 8'hA5);
      spi_sck = 1'b0; half();
      xfer(1'b0, 1'b0, 8, 8'h3C, 8'hA5, 8, 1'b1);
      chk("R2 oe while selected", oe_seen, 1);
      rd(2'd2, v); chk("R3 received 8-bit", v, 8'h3C);
      rd(2'd3, v); chk("R3 done flag", v, 8'h01);
      wr(2'd3, 8'h01);
      rd(2'd3, v); chk("R11 done cleared", v, 8'h00);

      // mode 3, 5 bits, no new write: sends low bits of last received
      wr(2'd0, 8'h0D); spi_sck = 1'b1; wr(2'd1, 8'h05); half();
      xfer(1'b1, 1'b1, 5, 8'h15, 8'h1C, 5, 1'b1);
      rd(2'd2, v); chk("R3 right-aligned 5-bit", v, 8'h15);

      // mode 1, 8 bits
      wr(2'd0, 8'h05); spi_sck = 1'b0; wr(2'd1, 8'h00); wr(2'd2, 8'h81); half();
      xfer(1'b0, 1'b1, 8, 8'hF0, 8'h81, 8, 1'b1);
      rd(2'd2, v); chk("R4 mode1 receive", v, 8'hF0);

      // mode 2, 3 bits
      wr(2'd0, 8'h09); spi_sck = 1'b1; wr(2'd1, 8'h03); wr(2'd2, 8'h06); half();
      xfer(1'b1, 1'b0, 3, 8'h05, 8'h06, 3, 1'b1);
      rd(2'd2, v); chk("R4 mode2 receive", v, 8'h05);
      wr(2'd3, 8'h0F);

      // overrun during a select window, then abort with no clocks
      spi_ss_n = 1'b0; half();
      wr(2'd2, 8'h77);
      rd(2'd3, v); chk("R6 overrun and busy", v, 8'h12);
      spi_ss_n = 1'b1; half(); half();
      rd(2'd2, v); chk("R6 data unchanged", v, 8'h05);
      rd(2'd3, v); chk("R8 abort flags", v, 8'h0B);
      wr(2'd3, 8'h02);
      rd(2'd3, v); chk("R11 only overrun cleared", v, 8'h09);
      wr(2'd3, 8'h0F);

      // abort after three of eight bits
      wr(2'd0, 8'h01); spi_sck = 1'b0; wr(2'd1, 8'h00); wr(2'd2, 8'h55); half();
      xfer(1'b0, 1'b0, 8, 8'hFF, 8'h00, 3, 1'b0);
      rd(2'd3, v); chk("R8 mid-character abort", v, 8'h09);
      rd(2'd2, v); chk("R8 data kept on abort", v, 8'h55);

      // interrupt gating
      chk("R10 irq masked", irq, 0);
      wr(2'd0, 8'h11);
      chk("R10 irq raised", irq, 1);
      wr(2'd3, 8'h0F);
      chk("R10 irq dropped", irq, 0);

      // start bit
      wr(2'd0, 8'h31);
      rd(2'd3, v); chk("R9 start sets done", v, 8'h01);
      rd(2'd0, v); chk("R9 start not stored", v, 8'h11);
      wr(2'd3, 8'h0F);

      // collision with master-enable
      wr(2'd0, 8'h03);
      spi_ss_n = 1'b0; half();
      chk("R7 oe off as master", spi_miso_oe, 0);
      spi_ss_n = 1'b1; half();
      rd(2'd3, v); chk("R7 collision flag", v, 8'h04);
      wr(2'd3, 8'h0F);

      // select configured as output: not a slave
      wr(2'd0, 8'h01); wr(2'd1, 8'h80);
      spi_ss_n = 1'b0; half();
      chk("R2 oe off with select output", spi_miso_oe, 0);
      rd(2'd3, v); chk("R2 not busy", v, 8'h00);
      spi_ss_n = 1'b1; half();
      rd(2'd3, v); chk("R2 no flags", v, 8'h00);

      repeat (4) @(negedge clk);
      finish_run();
   end
endmodule